// File: doc/BRIEF.md
# I2C Slave Address Match and Receive Tagger

This block works one level above an I2C bit receiver. The receiver reports whole bytes, acknowledge slots, start and stop conditions, and whether bits of an unfinished byte are held in its shift register. The block decides whether the device is being addressed. It checks the first byte after a start, or the first two bytes when the programmed address uses 10-bit form, against a programmed own address. It can also answer the general-call address when that answer is enabled. It gives the acknowledge decision that the bit layer drives onto SDA.

Each data byte the device receives becomes a 13-bit receive word with a one-cycle valid strobe. The low eight bits hold the data. The five bits above hold the sampled acknowledge value, a first-byte-of-frame marker, the master/slave origin, an error marker and the address type that opened the frame. An address match with the read bit set raises a level flag that asks the local side to supply transmit data. That flag stays up until the next start or stop.

Top module: `i2c_addr_tagger`

## Requirements
- R1: A receive word appears on `rx_word_o` with `rx_vld_o` high for one cycle, one cycle after the acknowledge-slot pulse of a received byte. Bits 7:0 hold the byte and bit 8 holds the sampled `ack_bit_i`. All outputs are 0 after reset.
- R2: Bit 9 is 1 in the first word written after a start (and, in slave mode, after the address phase). It is 0 in every later word of that frame.
- R3: With `master_i` high at a start, no address matching takes place. Every completed byte becomes a word with bit 10 set, and `ack_vld_o` stays low. Slave-mode words have bit 10 clear.
- R4: A start or stop that arrives while a data byte is unfinished writes that byte out with bit 11 set and bit 8 clear. An unfinished byte is either bits pending, in which case the data comes from `byte_i`, or a completed byte still waiting for its acknowledge slot. Bit 9 keeps its frame value in such a word.
- R5: Bit 12 is 1 in words of a frame opened by the general-call address, and 0 in words of a frame opened by the own address.
- R6: When `own_addr_i[14:10]` is not 11110, the address is in 7-bit form in `own_addr_i[7:1]`. An address byte matches when its bits 7:1 equal that field. One cycle after `byte_done_i`, `ack_vld_o` is 1 and `ack_o` gives the decision (1 = acknowledge, 0 = not).
- R7: When `own_addr_i[14:10]` is 11110, the address is in 10-bit form. A first byte whose bits 7:1 equal `own_addr_i[14:8]` with the write bit (bit 0 = 0) is acknowledged. The second byte must equal `own_addr_i[7:0]` to be acknowledged. Any mismatch gives a not-acknowledge, and the block ignores the bus until the next start.
- R8: The byte 0x00 is acknowledged as a general call only when `gc_en_i` is 1. When `gc_en_i` is 0 it is refused, and no words follow in that frame.
- R9: A matching address byte with bit 0 = 1 sets `slv_rd_req_o` one cycle after `byte_done_i`. A start or stop clears it. In 10-bit form, a read byte is accepted only after a full 10-bit write match with no stop in between.
- R10: Data bytes received in slave-receive state are acknowledged (`ack_o` = 1). After a read match, the bytes that follow produce neither `ack_vld_o` nor receive words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated start seen (pulse) |
| stop_i | input | 1 | Stop seen (pulse) |
| master_i | input | 1 | Local side owns the bus for the frame that is starting |
| byte_i | input | 8 | Receiver shift register contents |
| byte_done_i | input | 1 | Eight bits received (pulse) |
| bits_pend_i | input | 1 | Shift register holds 1 to 7 bits of a byte |
| ack_done_i | input | 1 | Acknowledge slot sampled (pulse) |
| ack_bit_i | input | 1 | SDA value sampled in the acknowledge slot |
| own_addr_i | input | 15 | Programmed own address, 7-bit or 10-bit form |
| gc_en_i | input | 1 | Allow acknowledging the general-call address |
| ack_vld_o | output | 1 | Acknowledge decision valid (pulse) |
| ack_o | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| rx_word_o | output | 13 | Receive word: status in 12:8, data in 7:0 |
| rx_vld_o | output | 1 | Receive word written (pulse) |
| slv_rd_req_o | output | 1 | Slave read requested |

## Verification
The assertions take for granted that the four event pulses (start, stop, byte done, acknowledge slot) arrive in separate cycles. They also assume that `byte_i` is stable whenever `byte_done_i` or a flush samples it, and that `own_addr_i`, `gc_en_i` and `master_i` change only while the bus is idle. The stimulus drives every pulse as a single-cycle event on the falling clock edge, one event per task call. It changes configuration only just before the stop that precedes a frame, so these conditions always hold.

// File: rtl/i2c_tag_pkg.sv
package i2c_tag_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 15;
  localparam int WORD_W = BYTE_W + 5;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADR1, ST_ADR2, ST_SRX, ST_STX, ST_MRX, ST_SKIP
  } tag_st_e;

  // field order fixes bit positions 12..8
  typedef struct packed {
    logic              adr_gc;
    logic              err;
    logic              mst;
    logic              first;
    logic              ack;
    logic [BYTE_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_tag_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              second_i,
  input  logic              ten_sel_i,
  output logic              own_hit_o,
  output logic              gc_hit_o,
  output logic              need_second_o,
  output logic              rd_o
);
  logic ten_mode, hi_hit;

  assign ten_mode = (own_addr_i[ADDR_W-1 -: 5] == TEN_PREFIX);
  assign hi_hit   = (byte_i[BYTE_W-1:1] == own_addr_i[ADDR_W-1:BYTE_W]);
  assign rd_o     = byte_i[0];

  always_comb begin
    own_hit_o     = 1'b0;
    gc_hit_o      = 1'b0;
    need_second_o = 1'b0;
    if (second_i) begin
      own_hit_o = ten_mode && (byte_i == own_addr_i[BYTE_W-1:0]);
    end else begin
      gc_hit_o = gc_en_i && (byte_i == '0);
      if (ten_mode) begin
        // read form only after a full 10-bit match since the last stop
        own_hit_o     = hi_hit && (!byte_i[0] || ten_sel_i);
        need_second_o = hi_hit && !byte_i[0];
      end else begin
        own_hit_o = (byte_i != '0) && (byte_i[BYTE_W-1:1] == own_addr_i[BYTE_W-1:1]);
      end
    end
  end
endmodule

// File: rtl/i2c_word_reg.sv
module i2c_word_reg
  import i2c_tag_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  rx_word_t word_i,
  output rx_word_t word_o,
  output logic     vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= wr_i;
      if (wr_i) word_o <= word_i;
    end
  end
endmodule

// File: rtl/i2c_addr_tagger.sv
module i2c_addr_tagger
  import i2c_tag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              master_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_done_i,
  input  logic              bits_pend_i,
  input  logic              ack_done_i,
  input  logic              ack_bit_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_vld_o,
  output logic              slv_rd_req_o
);
  tag_st_e           st_q;
  logic              first_q, gc_q, have_q, ten_sel_q;
  logic [BYTE_W-1:0] held_q;
  logic              own_hit, gc_hit, need_second, rd;
  logic              in_rx, flush, wr;
  rx_word_t          word_d, word_q;

  i2c_addr_match u_match (
    .byte_i        (byte_i),
    .own_addr_i    (own_addr_i),
    .gc_en_i       (gc_en_i),
    .second_i      (st_q == ST_ADR2),
    .ten_sel_i     (ten_sel_q),
    .own_hit_o     (own_hit),
    .gc_hit_o      (gc_hit),
    .need_second_o (need_second),
    .rd_o          (rd)
  );

  assign in_rx = (st_q == ST_SRX) || (st_q == ST_MRX);
  assign flush = (start_i || stop_i) && in_rx && (have_q || bits_pend_i);
  assign wr    = flush || (ack_done_i && have_q && in_rx);

  always_comb begin
    word_d.data   = have_q ? held_q : byte_i;
    word_d.ack    = flush ? 1'b0 : ack_bit_i;
    word_d.first  = first_q;
    word_d.mst    = (st_q == ST_MRX);
    word_d.err    = flush;
    word_d.adr_gc = gc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      first_q      <= 1'b0;
      gc_q         <= 1'b0;
      have_q       <= 1'b0;
      ten_sel_q    <= 1'b0;
      held_q       <= '0;
      ack_vld_o    <= 1'b0;
      ack_o        <= 1'b0;
      slv_rd_req_o <= 1'b0;
    end else begin
      ack_vld_o <= 1'b0;
      if (stop_i) begin
        st_q         <= ST_IDLE;
        have_q       <= 1'b0;
        first_q      <= 1'b0;
        ten_sel_q    <= 1'b0;
        slv_rd_req_o <= 1'b0;
      end else if (start_i) begin
        st_q         <= master_i ? ST_MRX : ST_ADR1;
        have_q       <= 1'b0;
        first_q      <= 1'b1;
        gc_q         <= 1'b0;
        slv_rd_req_o <= 1'b0;
      end else if (byte_done_i) begin
        unique case (st_q)
          ST_ADR1: begin
            ack_vld_o <= 1'b1;
            ack_o     <= own_hit || gc_hit;
            if (gc_hit) begin
              gc_q <= 1'b1;
              st_q <= ST_SRX;
            end else if (own_hit) begin
              if (need_second) st_q <= ST_ADR2;
              else if (rd) begin
                st_q         <= ST_STX;
                slv_rd_req_o <= 1'b1;
              end else st_q <= ST_SRX;
            end else st_q <= ST_SKIP;
          end
          ST_ADR2: begin
            ack_vld_o <= 1'b1;
            ack_o     <= own_hit;
            if (own_hit) begin
              st_q      <= ST_SRX;
              ten_sel_q <= 1'b1;
            end else st_q <= ST_SKIP;
          end
          ST_SRX: begin
            ack_vld_o <= 1'b1;
            ack_o     <= 1'b1;
            held_q    <= byte_i;
            have_q    <= 1'b1;
          end
          ST_MRX: begin
            held_q <= byte_i;
            have_q <= 1'b1;
          end
          default: ;
        endcase
      end else if (ack_done_i && have_q) begin
        have_q  <= 1'b0;
        first_q <= 1'b0;
      end
    end
  end

  i2c_word_reg u_word (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .word_i (word_d),
    .word_o (word_q),
    .vld_o  (rx_vld_o)
  );

  assign rx_word_o = word_q;

  a_r6_ack_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> $past(byte_done_i));
  a_r1_word_after_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_o |-> $past(ack_done_i || start_i || stop_i));
  a_r1_ack_bit_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_o && !rx_word_o[11]) |-> (rx_word_o[8] == $past(ack_bit_i)));
  a_r4_err_on_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_o && rx_word_o[11]) |-> $past(start_i || stop_i));
  a_r9_srr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slv_rd_req_o) |-> $past(start_i || stop_i));
  a_r9_srr_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slv_rd_req_o) |-> (ack_vld_o && ack_o));
  a_r10_no_word_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_rd_req_o |-> !rx_vld_o);
  a_r3_master_not_gc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_o && rx_word_o[10]) |-> !rx_word_o[12]);
endmodule

// File: tb/sim_i2c_addr_tagger.sv
`timescale 1ns/1ps
module sim_i2c_addr_tagger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 0, stop_i = 0, master_i = 0;
  logic [7:0]  byte_i = '0;
  logic        byte_done_i = 0, bits_pend_i = 0, ack_done_i = 0, ack_bit_i = 0;
  logic [14:0] own_addr_i = '0;
  logic        gc_en_i = 0;
  logic        ack_vld_o, ack_o, rx_vld_o, slv_rd_req_o;
  logic [12:0] rx_word_o;

  int checks = 0, fails = 0, n_words = 0;
  logic [12:0] last_word = '0;

  always #4 clk = ~clk;

  i2c_addr_tagger u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .stop_i(stop_i),
    .master_i(master_i), .byte_i(byte_i), .byte_done_i(byte_done_i),
    .bits_pend_i(bits_pend_i), .ack_done_i(ack_done_i), .ack_bit_i(ack_bit_i),
    .own_addr_i(own_addr_i), .gc_en_i(gc_en_i), .ack_vld_o(ack_vld_o),
    .ack_o(ack_o), .rx_word_o(rx_word_o), .rx_vld_o(rx_vld_o),
    .slv_rd_req_o(slv_rd_req_o));

  always @(negedge clk) if (rx_vld_o) begin
    n_words   <= n_words + 1;
    last_word <= rx_word_o;
  end

  // {own_addr, gc_en, address byte, expected ack, expected read request}
  localparam logic [25:0] TBL [10] = '{
    {15'h000A, 1'b0, 8'h0A, 1'b1, 1'b0},
    {15'h000A, 1'b0, 8'h0B, 1'b1, 1'b1},
    {15'h000A, 1'b0, 8'h0C, 1'b0, 1'b0},
    {15'h000A, 1'b1, 8'h00, 1'b1, 1'b0},
    {15'h000A, 1'b0, 8'h00, 1'b0, 1'b0},
    {15'h7B05, 1'b0, 8'hF6, 1'b1, 1'b0},
    {15'h7B05, 1'b0, 8'hF7, 1'b0, 1'b0},
    {15'h7B05, 1'b0, 8'hF4, 1'b0, 1'b0},
    {15'h00FE, 1'b0, 8'hFF, 1'b1, 1'b1},
    {15'h7B05, 1'b1, 8'h00, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1; @(negedge clk) start_i = 0; #1;
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop_i = 1; @(negedge clk) stop_i = 0; #1;
  endtask
  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_i = b; byte_done_i = 1; end
    @(negedge clk) byte_done_i = 0; #1;
  endtask
  task automatic slot(input logic a);
    @(negedge clk) begin ack_done_i = 1; ack_bit_i = a; end
    @(negedge clk) ack_done_i = 0; #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int nw;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ack_vld", ack_vld_o, 0);
    chk("R1 reset rx_vld", rx_vld_o, 0);
    chk("R9 reset read req", slv_rd_req_o, 0);
    rst_n = 1;

    // address table: R6 R7 R8 R9
    for (int i = 0; i < 10; i++) begin
      own_addr_i = TBL[i][25:11];
      gc_en_i    = TBL[i][10];
      pulse_stop();
      pulse_start();
      send(TBL[i][9:2]);
      chk($sformatf("R6 R7 R8 entry %0d ack_vld", i), ack_vld_o, 1);
      chk($sformatf("R6 R7 R8 entry %0d ack", i), ack_o, TBL[i][1]);
      chk($sformatf("R9 entry %0d read req", i), slv_rd_req_o, TBL[i][0]);
    end

    // 7-bit write, two data bytes
    own_addr_i = 15'h000A; gc_en_i = 0;
    pulse_stop(); pulse_start(); send(8'h0A);
    send(8'h55);
    chk("R10 data ack", {ack_vld_o, ack_o}, 2'b11);
    slot(0);
    chk("R1 R2 first word", last_word, 13'h0255);
    send(8'hA3); slot(1);
    chk("R1 R2 second word", last_word, 13'h01A3);
    nw = n_words; pulse_stop();
    chk("R4 clean stop writes nothing", n_words, nw);

    // partial byte at stop
    pulse_start(); send(8'h0A); send(8'h11); slot(0);
    chk("R2 word", last_word, 13'h0211);
    @(negedge clk) begin bits_pend_i = 1; byte_i = 8'h3C; end
    pulse_stop(); bits_pend_i = 0;
    chk("R4 partial at stop", last_word, 13'h083C);

    // completed byte awaiting ack slot, cut by repeated start
    pulse_start(); send(8'h0A); send(8'h42);
    nw = n_words; pulse_start();
    chk("R4 flush count", n_words, nw + 1);
    chk("R4 flush word", last_word, 13'h0A42);

    // general call
    gc_en_i = 1; pulse_stop(); pulse_start(); send(8'h00); send(8'h06); slot(0);
    chk("R5 general call word", last_word, 13'h1206);

    // 10-bit write then read after repeated start
    own_addr_i = 15'h7B05; gc_en_i = 0;
    pulse_stop(); pulse_start(); send(8'hF6); send(8'h05);
    chk("R7 second byte ack", {ack_vld_o, ack_o}, 2'b11);
    send(8'h99); slot(0);
    chk("R7 10-bit word", last_word, 13'h0299);
    pulse_start(); send(8'hF7);
    chk("R9 10-bit read ack", {ack_vld_o, ack_o}, 2'b11);
    chk("R9 10-bit read req", slv_rd_req_o, 1);
    nw = n_words; send(8'h77);
    chk("R10 no ack during read", ack_vld_o, 0);
    slot(0);
    chk("R10 no word during read", n_words, nw);
    pulse_stop();
    chk("R9 cleared by stop", slv_rd_req_o, 0);

    // 10-bit second byte mismatch
    pulse_start(); send(8'hF6); send(8'h06);
    chk("R7 second mismatch nack", {ack_vld_o, ack_o}, 2'b10);
    nw = n_words; send(8'h12);
    chk("R7 ignored after nack", ack_vld_o, 0);
    slot(0);
    chk("R7 no word after nack", n_words, nw);

    // master mode
    master_i = 1; pulse_stop(); pulse_start(); send(8'h5A);
    chk("R3 master no ack decision", ack_vld_o, 0);
    slot(1);
    chk("R3 master word", last_word, 13'h075A);
    master_i = 0;

    // general call refused
    own_addr_i = 15'h000A; gc_en_i = 0;
    pulse_stop(); pulse_start(); send(8'h00);
    chk("R8 refused gc", {ack_vld_o, ack_o}, 2'b10);
    nw = n_words; send(8'h44); slot(0);
    chk("R8 no word after refused gc", n_words, nw);

    finish_run();
  end
endmodule